// File: doc/BRIEF.md
# Serial Register Control Port

This block is the slave end of a four-wire serial configuration link. An external controller supplies the shift clock, pulls an active-low select low for the length of one transfer, sets a direction pin, and exchanges bits over a single data line. The data line is split at the block edge into an input, an output and an output enable, so the pad ring can build the bidirectional pin. Every transfer is sixteen bits long. An address byte comes first and a data byte follows. On a write, the data byte lands in the addressed register. On a read, the block shifts the register contents back out.

The register bank holds a parameterised number of 8-bit slots. The lower slots can be read and written, and their contents drive the `cfg_out` bus that the rest of the chip consumes. The upper slots are read-only and return bytes supplied on `ro_in`. Slot numbers past the end of the bank read as zero and ignore writes. All logic is clocked by the serial clock itself. The select line clears the transfer sequencer asynchronously, so a stray or aborted transfer never carries over into the next one.

Top module: `cfg_serial_port`

## Requirements
- R1: A transfer is 8 address bits followed by 8 data bits, both sent most significant bit first and sampled on rising `sclk` edges while `cs_n` is low.
- R2: Address bit 0 is ignored. The register slot is address bits 7..1, so addresses 2k and 2k+1 reach the same register.
- R3: When `rd_wr` is low, the data byte is stored in a read/write slot on the 16th rising edge and shows on `cfg_out[8*slot +: 8]` from then on. Without a completed write, the slots keep their value.
- R4: When `rd_wr` is high, `sd_oe` is still low after the 8th rising edge. After rising edge 8+k (k = 1..8), `sd_oe` is high and `sd_out` holds data bit 8-k of the addressed register.
- R5: `sd_oe` is low during write transfers and whenever `cs_n` is high. `cs_n` going high releases it at once, without waiting for an `sclk` edge.
- R6: If `cs_n` goes high before the 16th edge, no register changes, and the next transfer starts again with a fresh address byte.
- R7: Rising edges after the 16th in the same select window are ignored. No further write takes place, and on a read `sd_oe` stays high with `sd_out` holding data bit 0.
- R8: Slots RW_COUNT to N_REGS-1 (addresses 0xA0 to 0xBF with defaults) are read-only. They return byte `ro_in[8*(slot-RW_COUNT) +: 8]`, and writes to them change nothing.
- R9: Slots N_REGS and above (addresses 0xC0 to 0xFF with defaults) read as 0x00, and writes to them change nothing.
- R10: `rst` high at a rising `sclk` edge clears every read/write slot to 0x00 and returns the sequencer to waiting for an address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock from the external controller |
| rst | input | 1 | Synchronous active-high reset, sampled on `sclk` |
| cs_n | input | 1 | Active-low select; high asynchronously clears the sequencer |
| rd_wr | input | 1 | 1 = read transfer, 0 = write transfer |
| sd_in | input | 1 | Serial data from the pin into the block |
| sd_out | output | 1 | Serial read data toward the pin |
| sd_oe | output | 1 | Pin drive enable for `sd_out` |
| ro_in | input | 8*(N_REGS-RW_COUNT) | Bytes returned by the read-only slots |
| cfg_out | output | 8*RW_COUNT | Contents of the read/write slots |

## Verification
A sequencer that counts one edge too many or too few shows up in the first read as a byte shifted by one position, and as `sd_oe` rising one edge off. Both are visible within 9 to 16 edges of the select going low. A bad commit condition shows on `cfg_out` straight after the 16th edge of the write, either as a change that should not happen (an aborted frame, a read-only or missing slot, surplus edges) or as a change that does not happen. A read-only or missing slot that decodes wrongly returns a wrong byte on the very next read of that address.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int IDX_W     = ADDR_W - 1;
    localparam int BIT_CNT_W = $clog2(DATA_W);

    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e                 phase;
        logic [BIT_CNT_W-1:0]   bit_cnt;
        logic [IDX_W-1:0]       idx;
        logic                   is_rd;
        logic [DATA_W-1:0]      rd_sh;
        logic [DATA_W-2:0]      wr_sh;
        logic                   out_bit;
        logic                   oe;
    } xfer_state_t;

    typedef struct packed {
        logic                   en;
        logic [IDX_W-1:0]       idx;
        logic [DATA_W-1:0]      data;
    } wr_req_t;

    function automatic xfer_state_t idle_state();
        xfer_state_t s;
        s       = '0;
        s.phase = PH_ADDR;
        return s;
    endfunction

    function automatic logic last_bit(input logic [BIT_CNT_W-1:0] cnt);
        return cnt == BIT_CNT_W'(DATA_W - 1);
    endfunction

endpackage

// File: rtl/cfg_port_shifter.sv
module cfg_port_shifter
    import cfg_port_pkg::*;
(
    input  logic                 sclk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 rd_wr,
    input  logic                 sd_in,
    output logic [IDX_W-1:0]     rd_idx,
    input  logic [DATA_W-1:0]    rd_data,
    output wr_req_t              wr,
    output logic                 sd_out,
    output logic                 sd_oe
);

    xfer_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_ADDR: begin
                if (last_bit(st_q.bit_cnt)) begin
                    // address bit 0 arrives now and is dropped
                    st_d.phase   = PH_DATA;
                    st_d.bit_cnt = '0;
                    st_d.is_rd   = rd_wr;
                    st_d.rd_sh   = rd_data;
                end else begin
                    st_d.idx     = {st_q.idx[IDX_W-2:0], sd_in};
                    st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                end
            end
            PH_DATA: begin
                st_d.wr_sh = {st_q.wr_sh[DATA_W-3:0], sd_in};
                if (st_q.is_rd) begin
                    st_d.out_bit = st_q.rd_sh[DATA_W-1];
                    st_d.rd_sh   = {st_q.rd_sh[DATA_W-2:0], 1'b0};
                    st_d.oe      = 1'b1;
                end
                if (last_bit(st_q.bit_cnt)) begin
                    st_d.phase = PH_DONE;
                end else begin
                    st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            st_q <= idle_state();
        end else if (rst) begin
            st_q <= idle_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_idx   = st_q.idx;
    assign wr.en    = (st_q.phase == PH_DATA) && last_bit(st_q.bit_cnt) && !st_q.is_rd;
    assign wr.idx   = st_q.idx;
    assign wr.data  = {st_q.wr_sh, sd_in};
    assign sd_out   = st_q.out_bit;
    assign sd_oe    = st_q.oe;

    // R4: drive begins on the edge after the address byte
    a_r4_drive_after_address: assert property (@(posedge sclk) disable iff (rst || cs_n)
        $rose(sd_oe) |-> (st_q.phase == PH_DATA && st_q.bit_cnt == BIT_CNT_W'(1)));

    // R5: no drive while deselected
    a_r5_release_when_deselected: assert property (@(posedge sclk) disable iff (rst)
        cs_n |-> !sd_oe);

    // R5: drive only during a read
    a_r5_write_never_drives: assert property (@(posedge sclk) disable iff (rst || cs_n)
        (st_q.phase != PH_ADDR && !st_q.is_rd) |-> !sd_oe);

    // R7: a finished frame stays finished
    a_r7_done_is_final: assert property (@(posedge sclk) disable iff (rst || cs_n)
        (st_q.phase == PH_DONE) |=> (st_q.phase == PH_DONE));

    // R3: a commit closes the frame
    a_r3_commit_once: assert property (@(posedge sclk) disable iff (rst || cs_n)
        wr.en |=> (st_q.phase == PH_DONE));

endmodule

// File: rtl/cfg_port_regbank.sv
module cfg_port_regbank
    import cfg_port_pkg::*;
#(
    parameter int N_REGS   = 96,
    parameter int RW_COUNT = 80
) (
    input  logic                              sclk,
    input  logic                              rst,
    input  wr_req_t                           wr,
    input  logic [IDX_W-1:0]                  rd_idx,
    output logic [DATA_W-1:0]                 rd_data,
    input  logic [(N_REGS-RW_COUNT)*DATA_W-1:0] ro_in,
    output logic [RW_COUNT*DATA_W-1:0]        cfg_out
);

    localparam int RO_COUNT = N_REGS - RW_COUNT;
    localparam int RW_IDX_W = (RW_COUNT > 1) ? $clog2(RW_COUNT) : 1;
    localparam int RO_IDX_W = (RO_COUNT > 1) ? $clog2(RO_COUNT) : 1;
    localparam logic [IDX_W-1:0] RW_LIM = IDX_W'(RW_COUNT);
    localparam logic [IDX_W-1:0] N_LIM  = IDX_W'(N_REGS);

    logic [DATA_W-1:0] rw_q   [RW_COUNT];
    logic [DATA_W-1:0] ro_arr [RO_COUNT];
    logic [IDX_W-1:0]  ro_off;

    genvar g;
    generate
        for (g = 0; g < RW_COUNT; g++) begin : g_rw_out
            assign cfg_out[g*DATA_W +: DATA_W] = rw_q[g];
        end
        for (g = 0; g < RO_COUNT; g++) begin : g_ro_in
            assign ro_arr[g] = ro_in[g*DATA_W +: DATA_W];
        end
    endgenerate

    always_ff @(posedge sclk) begin
        if (rst) begin
            for (int i = 0; i < RW_COUNT; i++) begin
                rw_q[i] <= '0;
            end
        end else if (wr.en && (wr.idx < RW_LIM)) begin
            rw_q[RW_IDX_W'(wr.idx)] <= wr.data;
        end
    end

    assign ro_off = rd_idx - RW_LIM;

    always_comb begin
        if (rd_idx < RW_LIM) begin
            rd_data = rw_q[RW_IDX_W'(rd_idx)];
        end else if (rd_idx < N_LIM) begin
            rd_data = ro_arr[RO_IDX_W'(ro_off)];
        end else begin
            rd_data = '0;
        end
    end

    // R3: slots move only on a completed write
    a_r3_hold_without_write: assert property (@(posedge sclk) disable iff (rst)
        !wr.en |=> $stable(cfg_out));

    // R8: read-only slots ignore writes
    a_r8_ro_write_ignored: assert property (@(posedge sclk) disable iff (rst)
        (wr.en && wr.idx >= RW_LIM && wr.idx < N_LIM) |=> $stable(cfg_out));

    // R9: missing slots ignore writes
    a_r9_unimpl_write_ignored: assert property (@(posedge sclk) disable iff (rst)
        (wr.en && wr.idx >= N_LIM) |=> $stable(cfg_out));

    // R10: reset clears the bank
    a_r10_clear: assert property (@(posedge sclk)
        rst |=> (cfg_out == '0));

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
    import cfg_port_pkg::*;
#(
    parameter int N_REGS   = 96,
    parameter int RW_COUNT = 80
) (
    input  logic                                 sclk,
    input  logic                                 rst,
    input  logic                                 cs_n,
    input  logic                                 rd_wr,
    input  logic                                 sd_in,
    output logic                                 sd_out,
    output logic                                 sd_oe,
    input  logic [(N_REGS-RW_COUNT)*DATA_W-1:0]  ro_in,
    output logic [RW_COUNT*DATA_W-1:0]           cfg_out
);

    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_data;
    wr_req_t           wr;

    cfg_port_shifter u_shift (
        .sclk    (sclk),
        .rst     (rst),
        .cs_n    (cs_n),
        .rd_wr   (rd_wr),
        .sd_in   (sd_in),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .wr      (wr),
        .sd_out  (sd_out),
        .sd_oe   (sd_oe)
    );

    cfg_port_regbank #(
        .N_REGS   (N_REGS),
        .RW_COUNT (RW_COUNT)
    ) u_bank (
        .sclk    (sclk),
        .rst     (rst),
        .wr      (wr),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .ro_in   (ro_in),
        .cfg_out (cfg_out)
    );

endmodule

// File: tb/sim_cfg_serial_port.sv
module sim_cfg_serial_port;

    localparam int N_REGS   = 96;
    localparam int RW_COUNT = 80;
    localparam int RO_COUNT = N_REGS - RW_COUNT;

    logic clk = 1'b0;
    logic rst, cs_n, rd_wr, sd_in;
    logic sd_out, sd_oe;
    logic [RO_COUNT*8-1:0] ro_in;
    logic [RW_COUNT*8-1:0] cfg_out;
    logic [RW_COUNT*8-1:0] snap;

    always #4 clk = ~clk;

    cfg_serial_port #(.N_REGS(N_REGS), .RW_COUNT(RW_COUNT)) u0 (
        .sclk(clk), .rst(rst), .cs_n(cs_n), .rd_wr(rd_wr), .sd_in(sd_in),
        .sd_out(sd_out), .sd_oe(sd_oe), .ro_in(ro_in), .cfg_out(cfg_out)
    );

    typedef struct { logic [7:0] val; string req; } exp_t;
    exp_t exp_q[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: gathers the first 8 driven bits of each frame
    int mon_cnt = 0;
    logic [7:0] mon_sh = '0;
    always @(negedge clk) begin
        exp_t e;
        if (cs_n) begin
            mon_cnt = 0;
        end else if (sd_oe && mon_cnt < 8) begin
            mon_sh = {mon_sh[6:0], sd_out};
            mon_cnt++;
            if (mon_cnt == 8) begin
                if (exp_q.size() == 0) begin
                    check("R4", 32'd1, 32'd0, "unexpected read byte");
                end else begin
                    e = exp_q.pop_front();
                    check(e.req, {24'd0, mon_sh}, {24'd0, e.val}, "read byte");
                end
            end
        end
    end

    // driver: one full frame plus optional surplus edges
    task automatic xfer(input logic rw, input logic [7:0] addr, input logic [7:0] wdata,
                        input int extra, input string req, input logic [7:0] rexp);
        logic [7:0] seen;
        seen = '0;
        if (rw) exp_q.push_back('{rexp, req});
        @(negedge clk); #1;
        cs_n  = 1'b0;
        rd_wr = rw;
        for (int i = 0; i < 16; i++) begin
            if (i < 8) sd_in = addr[7-i];
            else       sd_in = wdata[15-i];
            @(posedge clk);
            @(negedge clk);
            if (i >= 8) seen[15-i] = sd_out;
            if (i == 7) check("R4", {31'd0, sd_oe}, 32'd0, "oe after address byte");
            if (i == 8) check(rw ? "R4" : "R5", {31'd0, sd_oe}, {31'd0, rw}, "oe at first data edge");
            #1;
        end
        for (int e = 0; e < extra; e++) begin
            sd_in = ~sd_in;
            @(posedge clk);
            @(negedge clk);
            if (rw) check("R7", {30'd0, sd_oe, sd_out}, {30'd0, 1'b1, seen[0]}, "held after frame");
            #1;
        end
        cs_n  = 1'b1;
        rd_wr = 1'b0;
        #1;
        check("R5", {31'd0, sd_oe}, 32'd0, "released on deselect");
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic abort_xfer(input logic [7:0] addr, input logic [7:0] wdata, input int edges);
        @(negedge clk); #1;
        cs_n  = 1'b0;
        rd_wr = 1'b0;
        for (int i = 0; i < edges; i++) begin
            if (i < 8) sd_in = addr[7-i];
            else       sd_in = wdata[15-i];
            @(posedge clk);
            @(negedge clk); #1;
        end
        cs_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; cs_n = 1'b1; rd_wr = 1'b0; sd_in = 1'b0;
        for (int k = 0; k < RO_COUNT; k++) ro_in[k*8 +: 8] = 8'hC0 ^ 8'(k);
        repeat (3) @(negedge clk);
        check("R10", {31'd0, sd_oe}, 32'd0, "oe in reset");
        check("R10", {31'd0, |cfg_out}, 32'd0, "bank cleared in reset");
        #1 rst = 1'b0;

        // R1 R3: plain writes and reads
        xfer(1'b0, 8'h00, 8'hA5, 0, "R3", 8'h00);
        check("R3", {24'd0, cfg_out[0 +: 8]}, 32'hA5, "slot 0 after write");
        xfer(1'b1, 8'h00, 8'h00, 0, "R1", 8'hA5);
        xfer(1'b0, 8'h9E, 8'hFF, 0, "R3", 8'h00);
        check("R3", {24'd0, cfg_out[79*8 +: 8]}, 32'hFF, "slot 79 after write");
        xfer(1'b1, 8'h9E, 8'h00, 0, "R1", 8'hFF);
        xfer(1'b0, 8'h04, 8'h01, 0, "R3", 8'h00);
        xfer(1'b1, 8'h04, 8'h00, 0, "R4", 8'h01);

        // R2: odd address aliases even one
        xfer(1'b0, 8'h13, 8'h3C, 0, "R2", 8'h00);
        check("R2", {24'd0, cfg_out[9*8 +: 8]}, 32'h3C, "odd address hits slot 9");
        xfer(1'b1, 8'h12, 8'h00, 0, "R2", 8'h3C);

        // R6: aborted frames
        abort_xfer(8'h00, 8'h00, 12);
        check("R6", {24'd0, cfg_out[0 +: 8]}, 32'hA5, "slot 0 after aborted write");
        abort_xfer(8'hFF, 8'h00, 5);
        xfer(1'b1, 8'h00, 8'h00, 0, "R6", 8'hA5);

        // R7: surplus edges
        xfer(1'b0, 8'h02, 8'h5A, 6, "R7", 8'h00);
        check("R7", {24'd0, cfg_out[1*8 +: 8]}, 32'h5A, "slot 1 after surplus edges");
        xfer(1'b1, 8'h02, 8'h00, 5, "R7", 8'h5A);

        // R8: read-only slots
        xfer(1'b1, 8'hA0, 8'h00, 0, "R8", 8'hC0);
        xfer(1'b1, 8'hBF, 8'h00, 0, "R8", 8'hCF);
        snap = cfg_out;
        xfer(1'b0, 8'hA2, 8'h11, 0, "R8", 8'h00);
        check("R8", {31'd0, cfg_out == snap}, 32'd1, "bank unchanged by read-only write");
        xfer(1'b1, 8'hA3, 8'h00, 0, "R8", 8'hC1);

        // R9: missing slots
        xfer(1'b1, 8'hC4, 8'h00, 0, "R9", 8'h00);
        snap = cfg_out;
        xfer(1'b0, 8'hFE, 8'h77, 0, "R9", 8'h00);
        check("R9", {31'd0, cfg_out == snap}, 32'd1, "bank unchanged by missing-slot write");
        xfer(1'b1, 8'hFE, 8'h00, 0, "R9", 8'h00);

        // R10: reset in mid-run
        @(negedge clk); #1 rst = 1'b1;
        @(posedge clk); @(negedge clk); #1 rst = 1'b0;
        check("R10", {31'd0, |cfg_out}, 32'd0, "bank cleared by reset");
        xfer(1'b1, 8'h00, 8'h00, 0, "R10", 8'h00);

        repeat (4) @(negedge clk);
        check("R4", exp_q.size(), 32'd0, "all expected reads seen");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule